// File: doc/BRIEF.md
# Frame-Sync Sample Rate Generator

This block derives a slower bit clock and a frame marker for a serial receiver from one fast input clock. A programmable divider produces the divided clock (`clkg`), and a frame generator built on top of it drives the frame pulse (`fsg`). Both outputs are registered levels in the input clock domain. Every change of `fsg` lands on the same input-clock edge as a rising edge of `clkg`.

Two frame modes exist. In free-running mode (`sync_en` = 0) the frame pulse repeats on a programmed number of divided-clock periods, and the external frame input is ignored. In synchronized mode (`sync_en` = 1) the frame period setting plays no part. The block watches the external frame input through a two-flop synchronizer. On each rising edge it restarts the divider, so the divided clock takes a fixed phase relative to that edge. It then issues exactly one frame pulse. The mode and the three count values are static settings, changed only while reset is held.

Top module: `fsync_rate_gen`

## Requirements
- R1: While `rst_n` is sampled low, `clkg` and `fsg` are both 0 from the next clock edge onward.
- R2: `clkg` has a period of `div_val`+1 input clock cycles, and its high phase lasts (`div_val`+2)/2 cycles (integer division), so with an odd count the high phase is the longer one. With `div_val` = 0, `clkg` stays high and every input cycle counts as one divided-clock period.
- R3: At the first clock edge where `rst_n` is sampled high, `clkg` rises. In free-running mode `fsg` rises on that same edge.
- R4: `fsg` changes only on an input clock edge at which the divider wraps to its first count, which is where `clkg` rises.
- R5: In free-running mode, a frame pulse begins every `per_val`+1 divided-clock periods.
- R6: Each frame pulse holds `fsg` high for `wid_val`+1 divided-clock periods. If `wid_val` ≥ `per_val` in free-running mode, `fsg` stays high.
- R7: In synchronized mode, `fsg` never rises unless the external frame input showed a rising edge, whatever `per_val` holds.
- R8: In synchronized mode, a rising edge of `fsync_in` first sampled at clock edge e restarts the divider at edge e+2. There `clkg` rises and a single frame pulse of `wid_val`+1 divided-clock periods begins, and no further pulse follows it.
- R9: In free-running mode, `fsync_in` has no effect on `clkg` or `fsg`.
- R10: Holding `fsync_in` high for many cycles counts as one edge and gives a single frame pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; all state updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync_in | input | 1 | External frame input, asynchronous to `clk` |
| sync_en | input | 1 | 0 = free-running frames, 1 = frames triggered by the external input |
| div_val | input | DIV_W (8) | Divided-clock period minus one, in input cycles |
| per_val | input | PER_W (12) | Frame period minus one, in divided-clock periods |
| wid_val | input | WID_W (8) | Frame pulse width minus one, in divided-clock periods |
| clkg | output | 1 | Divided clock |
| fsg | output | 1 | Frame pulse |

## Verification
The in-line assertions watch four cycle-level properties on every clock edge. `fsg` holds steady on every edge where the divider does not wrap. `clkg` goes high after each natural wrap. A restart leaves the divider at its first count with `clkg` high. In synchronized mode `fsg` never rises without a detected external edge. The exact cycle positions need the bench's arithmetic sweeps over all small count combinations, in both modes. These cover the divided-clock duty split, the frame period and width, the two-edge restart latency and the single pulse per external edge. Only a long scenario can show that a held-high external input gives one pulse, or that the input leaves free-running frames untouched.

// File: rtl/fsrg_pkg.sv
// Shared types for the frame-sync sample rate generator.
package fsrg_pkg;

    // Source of frame pulse starts.
    typedef enum logic {
        FRAME_FREE = 1'b0,  // internal period counter triggers frames
        FRAME_SYNC = 1'b1   // detected external edges trigger frames
    } fsrg_mode_e;

endpackage

// File: rtl/fsrg_edge_det.sv
// Synchronizes an asynchronous level into the clk domain through STAGES
// flops and flags its rising edge for one cycle.
// Assumes: async_in may change at any time; STAGES >= 2.
module fsrg_edge_det #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);

    localparam int unsigned LAST = STAGES - 1;

    // chain_q[0..LAST] synchronizer, chain_q[STAGES] one-cycle history
    logic [STAGES:0] chain_q;

    // Shift the input through the synchronizer and history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[LAST:0], async_in};
        end
    end

    assign rise = chain_q[LAST] & ~chain_q[STAGES];

endmodule

// File: rtl/fsrg_clk_div.sv
// Divides clk by (div_val + 1) into a registered clkg level. The high phase
// spans (div_val + 2) / 2 cycles. tick marks the edge at which the counter
// returns to zero, which is where clkg rises. reload forces that return.
// Assumes: div_val is held steady outside reset.
module fsrg_clk_div #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    input  logic             reload,
    output logic             clkg,
    output logic             tick
);

    localparam int unsigned   HW  = DIV_W + 1;
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] cnt_nx;
    logic [HW-1:0]    high_len;

    assign high_len = ({1'b0, div_val} + HW'(2)) >> 1;

    // Next count: restart on reload or at the end of the period.
    always_comb begin
        if (reload || (cnt_q >= div_val)) begin
            cnt_nx = '0;
        end else begin
            cnt_nx = cnt_q + ONE;
        end
    end

    assign tick = (cnt_nx == '0);

    // Register the count and the divided clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            clkg  <= 1'b0;
        end else begin
            cnt_q <= cnt_nx;
            clkg  <= ({1'b0, cnt_nx} < high_len);
        end
    end

    // R2: after a natural wrap the divided clock is high
    p_high_after_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (div_val != '0) && (cnt_q == div_val) && !reload |=> clkg);

    // R8: a restart leaves the divider at its first count with clkg high
    p_reload_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (cnt_q == '0) && clkg);

endmodule

// File: rtl/fsrg_frame_gen.sv
// Builds the frame pulse from divider ticks. A frame starts on a tick when
// start_req is set, or in periodic mode when per_val + 1 ticks have elapsed.
// It then stays high for wid_val + 1 ticks.
// Assumes: tick is set on every cycle where start_req is set.
module fsrg_frame_gen #(
    parameter int unsigned PER_W = 12,
    parameter int unsigned WID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start_req,
    input  logic             periodic,
    input  logic [PER_W-1:0] per_val,
    input  logic [WID_W-1:0] wid_val,
    output logic             fsg
);

    localparam logic [PER_W-1:0] P_ONE = PER_W'(1);
    localparam logic [WID_W-1:0] W_ONE = WID_W'(1);

    logic [PER_W-1:0] pcnt_q;
    logic [WID_W-1:0] wleft_q;
    logic             begin_frame;

    assign begin_frame = tick && (start_req || (periodic && (pcnt_q >= per_val)));

    // Count divided-clock periods between periodic frame starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (begin_frame) begin
            pcnt_q <= '0;
        end else if (tick && periodic) begin
            pcnt_q <= pcnt_q + P_ONE;
        end
    end

    // Raise the pulse at a frame start and drop it after wid_val + 1 ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsg     <= 1'b0;
            wleft_q <= '0;
        end else if (begin_frame) begin
            fsg     <= 1'b1;
            wleft_q <= wid_val;
        end else if (tick) begin
            if (wleft_q != '0) begin
                wleft_q <= wleft_q - W_ONE;
            end else begin
                fsg <= 1'b0;
            end
        end
    end

    // R4: the frame pulse moves only on divider ticks
    p_fsg_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(fsg));

endmodule

// File: rtl/fsync_rate_gen.sv
// Top of the frame-sync sample rate generator. In free mode the divider
// runs from reset and frames repeat on per_val. In sync mode each
// synchronized rising edge of fsync_in restarts the divider and starts one
// frame, and per_val is unused.
// Assumes: sync_en and the count values change only while reset is held.
module fsync_rate_gen #(
    parameter int unsigned DIV_W       = 8,
    parameter int unsigned PER_W       = 12,
    parameter int unsigned WID_W       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync_in,
    input  logic             sync_en,
    input  logic [DIV_W-1:0] div_val,
    input  logic [PER_W-1:0] per_val,
    input  logic [WID_W-1:0] wid_val,
    output logic             clkg,
    output logic             fsg
);

    import fsrg_pkg::*;

    fsrg_mode_e mode;
    logic       restart_q;
    logic       ext_rise;
    logic       reload;
    logic       start_req;
    logic       tick;

    assign mode = sync_en ? FRAME_SYNC : FRAME_FREE;

    // Flag the first cycle after reset so the divider starts in phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            restart_q <= 1'b1;
        end else begin
            restart_q <= 1'b0;
        end
    end

    fsrg_edge_det #(.STAGES(SYNC_STAGES)) edge_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (fsync_in),
        .rise     (ext_rise)
    );

    assign reload    = restart_q || ((mode == FRAME_SYNC) && ext_rise);
    assign start_req = (mode == FRAME_SYNC) ? ext_rise : restart_q;

    fsrg_clk_div #(.DIV_W(DIV_W)) div_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_val (div_val),
        .reload  (reload),
        .clkg    (clkg),
        .tick    (tick)
    );

    fsrg_frame_gen #(.PER_W(PER_W), .WID_W(WID_W)) frame_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .start_req (start_req),
        .periodic  (mode == FRAME_FREE),
        .per_val   (per_val),
        .wid_val   (wid_val),
        .fsg       (fsg)
    );

    // R7: in sync mode no frame starts without a detected external edge
    p_no_frame_without_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_en && !ext_rise |=> !$rose(fsg));

endmodule

// File: tb/fsync_rate_gen_tb_top.sv
`timescale 1ns/1ps
// Sweeps small count settings in both modes and compares every cycle of
// clkg and fsg against values computed from the requirements.
module fsync_rate_gen_tb_top;

    logic       clk      = 1'b0;
    logic       rst_n    = 1'b0;
    logic       fsync_in = 1'b0;
    logic       sync_en  = 1'b0;
    logic [7:0]  div_val = '0;
    logic [11:0] per_val = '0;
    logic [7:0]  wid_val = '0;
    logic       clkg;
    logic       fsg;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    int cd, cp, cw;

    always #2.5 clk = ~clk;

    fsync_rate_gen dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fsync_in (fsync_in),
        .sync_en  (sync_en),
        .div_val  (div_val),
        .per_val  (per_val),
        .wid_val  (wid_val),
        .clkg     (clkg),
        .fsg      (fsg)
    );

    // Count one check and report it on mismatch.
    task automatic chk(input bit act, input bit exp, input string tag, input string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s d=%0d p=%0d w=%0d: actual %0b expected %0b",
                     tag, what, cd, cp, cw, act, exp);
        end
    endtask

    // Hold reset with a new configuration, check R1, then release.
    task automatic do_reset(input bit smode, input int d, input int p, input int w);
        @(negedge clk);
        rst_n    = 1'b0;
        fsync_in = 1'b0;
        sync_en  = smode;
        cd = d; cp = p; cw = w;
        div_val = 8'(d);
        per_val = 12'(p);
        wid_val = 8'(w);
        repeat (3) @(negedge clk);
        chk(clkg, 1'b0, "R1", "clkg in reset");
        chk(fsg,  1'b0, "R1", "fsg in reset");
        rst_n = 1'b1;
    endtask

    // Compare len cycles after an aligning edge. mode 0: periodic frames,
    // 1: one frame, 2: no frame. Optional fsync_in pulse and drop points.
    task automatic run_stream(input int len, input int mode, input int pulse_at,
                              input int drop_at, input string ctag, input string ftag);
        for (int n = 0; n < len; n++) begin
            int  cnt;
            int  k;
            bit  ec;
            bit  ef;
            string ct;
            string ft;
            @(negedge clk);
            cnt = n % (cd + 1);
            k   = n / (cd + 1);
            ec  = (cnt < (cd + 2) / 2);
            case (mode)
                0:       ef = ((k % (cp + 1)) <= cw);
                1:       ef = (k <= cw);
                default: ef = 1'b0;
            endcase
            ct = ctag;
            ft = ftag;
            if (n == 0 && mode == 0 && pulse_at < 0) begin
                ct = "R3";
                ft = "R3";
            end
            chk(clkg, ec, ct, "clkg");
            chk(fsg,  ef, ft, "fsg");
            if (n == pulse_at)     fsync_in = 1'b1;
            if (n == pulse_at + 4) fsync_in = 1'b0;
            if (n == drop_at)      fsync_in = 1'b0;
        end
    endtask

    // Raise fsync_in now; return at the negedge just before the restart edge.
    task automatic ext_edge();
        fsync_in = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        // Free-running sweep: R2 R3 R4 R5 R6
        for (int d = 0; d < 4; d++) begin
            for (int p = 0; p < 4; p++) begin
                for (int w = 0; w <= p; w++) begin
                    do_reset(1'b0, d, p, w);
                    run_stream(3 * (p + 1) * (d + 1) + 2, 0, -1, -1, "R2", "R4 R5 R6");
                end
            end
        end

        // R9: an external pulse in free mode leaves both outputs on schedule
        do_reset(1'b0, 2, 2, 1);
        run_stream(60, 0, 7, -1, "R9", "R9");
        do_reset(1'b0, 3, 1, 0);
        run_stream(50, 0, 5, -1, "R9", "R9");

        // Sync mode sweep: R7 R8 R10
        for (int d = 0; d < 4; d++) begin
            for (int w = 0; w < 3; w++) begin
                int p;
                int slen;
                p    = (d + w) % 4;
                slen = ((w + 1) + (p + 1) + 4) * (d + 1) + 10;
                do_reset(1'b1, d, p, w);
                run_stream(2 * (p + 1) * (d + 1) + 3 + d, 2, -1, -1, "R2", "R7");
                ext_edge();
                run_stream(slen, 1, -1, 0, "R8", "R8");
                ext_edge();
                run_stream(slen, 1, -1, 8, "R8 R10", "R8 R10");
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule